// File: doc/BRIEF.md
# Four-Phase Integer Execute Sequencer

This block runs the integer register-register and register-immediate instructions of a small core whose register file has a single port. Each instruction uses four core clocks. The block reads the first source register, then reads the second source register, then runs the ALU, then writes the result back. All four clocks use the same register port. The fetch side presents a 32-bit instruction word with a valid flag. The block takes the word in its first phase and holds a private copy, so fetch can move on to the next word while the current one is executing.

The block decodes the two integer opcode groups and drives the register port address and the read and write strobes. It feeds the ALU and registers the result. Any encoding it does not recognise runs through the same four clocks without a write. In the write-back clock the block raises a trap together with the offending word, and the sequencer then goes on to the next instruction.

Top module: `exec_seq4`

## Requirements
- R1: An instruction is taken (`instr_take` high) only in the first phase while `instr_valid` is high. With words always available, successive takes are exactly 4 clocks apart.
- R2: The register port is used in this order. Phase 1 reads the address in word bits [19:15]. Phase 2 reads bits [24:20] for the register form. Phase 3 makes no access. Phase 4 writes to bits [11:7].
- R3: The register port is never read and written in the same clock.
- R4: For the immediate form (opcode bits [6:0] = 0010011), phase 2 makes no register read. The second operand is word bits [31:20], sign-extended.
- R5: A source register number of 0 gives an operand of zero, whatever value arrives on `rf_rdata`.
- R6: A legal instruction whose destination is register 0 produces no write strobe.
- R7: The result follows funct3 (word bits [14:12]): 000 add, or subtract for the register form when bit 30 is set; 001 shift left; 010 signed less-than; 011 unsigned less-than; 100 xor; 101 logical right shift, or arithmetic when bit 30 is set; 110 or; 111 and. A less-than result is 0 or 1. Shift amounts use the low 5 bits of the second operand.
- R8: Only two opcodes are legal: 0110011 (register form) and 0010011 (immediate form). In the register form, bits [31:25] must be 0000000, or 0100000 with funct3 000 or 101. In the immediate form, funct3 001 needs bits [31:25] = 0000000, and funct3 101 needs 0000000 or 0100000. The other immediate funct3 values are always legal.
- R9: For an illegal word, phase 4 drives `trap` high, `trap_word` equal to the word, and no write and no `retire`. The next instruction is then taken normally.
- R10: After reset the block is in phase 1. While `instr_valid` is low it stays there with no take, no read and no write.
- R11: `retire` is high for exactly the write-back clock of every legal instruction, and `trap` is low then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Fetch side has a word ready |
| instr_word | input | 32 | Instruction word from fetch |
| instr_take | output | 1 | Word accepted this clock |
| rf_addr | output | 5 | Register port address |
| rf_re | output | 1 | Register port read strobe |
| rf_we | output | 1 | Register port write strobe |
| rf_wdata | output | XLEN | Write-back data |
| rf_rdata | input | XLEN | Read data, valid in the same clock as the address |
| trap | output | 1 | Illegal-instruction trap, in write-back clock |
| trap_word | output | 32 | Word that caused the trap |
| retire | output | 1 | Legal instruction completes this clock |

## Verification
The assertions assume that the register port returns read data combinationally, in the same clock as the address. They also assume that reset is held for at least one clock edge before any word is offered. The bench drives all inputs at the falling edge. Its register model answers reads from the current address at once, with register 0 deliberately holding a nonzero value. Valid words are offered only at phase boundaries of the bench's own schedule, with idle stretches between some of them. Random words mix legal encodings, near-miss funct7 values and arbitrary opcodes, so that both the legal decodes and the trap path are exercised.

// File: rtl/seq4_pkg.sv
package seq4_pkg;

    localparam int ILEN    = 32;
    localparam int REG_AW  = 5;
    localparam int IMM_W   = 12;
    localparam logic [6:0] OPC_IMM = 7'b0010011;
    localparam logic [6:0] OPC_REG = 7'b0110011;
    localparam logic [6:0] F7_BASE = 7'b0000000;
    localparam logic [6:0] F7_ALT  = 7'b0100000;

    typedef enum logic [1:0] {
        PH_SRC1 = 2'd0,
        PH_SRC2 = 2'd1,
        PH_EXEC = 2'd2,
        PH_WRBK = 2'd3
    } phase_t;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
        ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR,  ALU_AND
    } alu_op_t;

    typedef struct packed {
        logic              legal;
        logic              use_imm;
        alu_op_t           op;
        logic [REG_AW-1:0] rs1;
        logic [REG_AW-1:0] rs2;
        logic [REG_AW-1:0] rd;
        logic [IMM_W-1:0]  imm;
    } dec_t;

    function automatic alu_op_t base_op(input logic [2:0] f3);
        case (f3)
            3'b000:  return ALU_ADD;
            3'b001:  return ALU_SLL;
            3'b010:  return ALU_SLT;
            3'b011:  return ALU_SLTU;
            3'b100:  return ALU_XOR;
            3'b101:  return ALU_SRL;
            3'b110:  return ALU_OR;
            default: return ALU_AND;
        endcase
    endfunction

    function automatic dec_t decode_word(input logic [ILEN-1:0] w);
        dec_t       d;
        logic [2:0] f3;
        logic [6:0] f7;
        logic       alt_ok;
        f3        = w[14:12];
        f7        = w[31:25];
        alt_ok    = (f7 == F7_BASE) || (f7 == F7_ALT);
        d.rs1     = w[19:15];
        d.rs2     = w[24:20];
        d.rd      = w[11:7];
        d.imm     = w[31:20];
        d.use_imm = (w[6:0] == OPC_IMM);
        d.op      = base_op(f3);
        d.legal   = 1'b0;
        if (w[6:0] == OPC_REG) begin
            case (f3)
                3'b000: begin
                    d.op    = f7[5] ? ALU_SUB : ALU_ADD;
                    d.legal = alt_ok;
                end
                3'b101: begin
                    d.op    = f7[5] ? ALU_SRA : ALU_SRL;
                    d.legal = alt_ok;
                end
                default: d.legal = (f7 == F7_BASE);
            endcase
        end else if (w[6:0] == OPC_IMM) begin
            case (f3)
                3'b001:  d.legal = (f7 == F7_BASE);
                3'b101: begin
                    d.op    = f7[5] ? ALU_SRA : ALU_SRL;
                    d.legal = alt_ok;
                end
                default: d.legal = 1'b1;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/seq4_phase.sv
module seq4_phase
    import seq4_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_t phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_SRC1;
        end else begin
            case (phase)
                PH_SRC1: if (start) phase <= PH_SRC2;
                PH_SRC2: phase <= PH_EXEC;
                PH_EXEC: phase <= PH_WRBK;
                default: phase <= PH_SRC1;
            endcase
        end
    end

    AST_START_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SRC1 && start) |=> (phase == PH_SRC2)) else $error("start"); // R1
    AST_SRC2_TO_EXEC: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SRC2) |=> (phase == PH_EXEC)) else $error("src2"); // R2
    AST_EXEC_TO_WRBK: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC) |=> (phase == PH_WRBK)) else $error("exec"); // R2
    AST_WRBK_TO_SRC1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WRBK) |=> (phase == PH_SRC1)) else $error("wrbk"); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SRC1 && !start) |=> (phase == PH_SRC1)) else $error("idle"); // R10

endmodule

// File: rtl/seq4_decode.sv
module seq4_decode
    import seq4_pkg::*;
(
    input  logic [ILEN-1:0] word,
    output dec_t            dec
);

    always_comb dec = decode_word(word);

endmodule

// File: rtl/seq4_alu.sv
module seq4_alu
    import seq4_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_t         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0] shamt;
    assign shamt = b[SHW-1:0];

    always_comb begin
        case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_SLL:  y = a << shamt;
            ALU_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SLTU: y = {{(XLEN-1){1'b0}}, (a < b)};
            ALU_XOR:  y = a ^ b;
            ALU_SRL:  y = a >> shamt;
            ALU_SRA:  y = $unsigned($signed(a) >>> shamt);
            ALU_OR:   y = a | b;
            default:  y = a & b;
        endcase
    end

endmodule

// File: rtl/exec_seq4.sv
module exec_seq4
    import seq4_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [31:0]     instr_word,
    output logic            instr_take,
    output logic [4:0]      rf_addr,
    output logic            rf_re,
    output logic            rf_we,
    output logic [XLEN-1:0] rf_wdata,
    input  logic [XLEN-1:0] rf_rdata,
    output logic            trap,
    output logic [31:0]     trap_word,
    output logic            retire
);

    phase_t            phase;
    dec_t              dec;
    logic [ILEN-1:0]   ir;
    logic [XLEN-1:0]   opa, opb, res, alu_y;
    logic [XLEN-1:0]   src1_val, src2_val, imm_ext;
    logic [REG_AW-1:0] fetch_rs1;

    seq4_phase u_phase (
        .clk   (clk),
        .rst   (rst),
        .start (instr_valid),
        .phase (phase)
    );

    seq4_decode u_dec (
        .word (ir),
        .dec  (dec)
    );

    seq4_alu #(.XLEN(XLEN)) u_alu (
        .op (dec.op),
        .a  (opa),
        .b  (opb),
        .y  (alu_y)
    );

    assign instr_take = (phase == PH_SRC1) && instr_valid;
    assign fetch_rs1  = instr_word[19:15];
    assign imm_ext    = {{(XLEN-IMM_W){dec.imm[IMM_W-1]}}, dec.imm};
    assign src1_val   = (fetch_rs1 == '0) ? '0 : rf_rdata;
    assign src2_val   = dec.use_imm ? imm_ext
                      : ((dec.rs2 == '0) ? '0 : rf_rdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ir  <= '0;
            opa <= '0;
            opb <= '0;
            res <= '0;
        end else begin
            if (instr_take) begin
                ir  <= instr_word;
                opa <= src1_val;
            end
            if (phase == PH_SRC2) opb <= src2_val;
            if (phase == PH_EXEC) res <= alu_y;
        end
    end

    always_comb begin
        rf_addr = '0;
        rf_re   = 1'b0;
        rf_we   = 1'b0;
        case (phase)
            PH_SRC1: begin
                rf_addr = fetch_rs1;
                rf_re   = instr_valid;
            end
            PH_SRC2: begin
                rf_addr = dec.rs2;
                rf_re   = !dec.use_imm;
            end
            PH_WRBK: begin
                rf_addr = dec.rd;
                rf_we   = dec.legal && (dec.rd != '0);
            end
            default: ;
        endcase
    end

    assign rf_wdata  = res;
    assign trap      = (phase == PH_WRBK) && !dec.legal;
    assign retire    = (phase == PH_WRBK) && dec.legal;
    assign trap_word = ir;

    AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rf_re && rf_we)) else $error("port"); // R3
    AST_NO_X0_WRITE: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_addr != '0)) else $error("x0"); // R6
    AST_TRAP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        trap |-> (!rf_we && !retire)) else $error("trap"); // R9
    AST_TAKE_SPACING: assert property (@(posedge clk) disable iff (rst)
        instr_take |=> !instr_take) else $error("take"); // R1
    AST_RETIRE_AFTER_EXEC: assert property (@(posedge clk) disable iff (rst)
        retire |=> !retire) else $error("retire"); // R11

endmodule

// File: tb/exec_seq4_tb_top.sv
module exec_seq4_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        instr_take, rf_re, rf_we, trap, retire;
    logic [4:0]  rf_addr;
    logic [31:0] rf_wdata, rf_rdata, trap_word;

    logic [31:0] regs [32];
    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int last_take = 0;
    bit chained = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    exec_seq4 #(.XLEN(32)) dut_i (
        .clk (clk), .rst (rst),
        .instr_valid (instr_valid), .instr_word (instr_word),
        .instr_take (instr_take),
        .rf_addr (rf_addr), .rf_re (rf_re), .rf_we (rf_we),
        .rf_wdata (rf_wdata), .rf_rdata (rf_rdata),
        .trap (trap), .trap_word (trap_word), .retire (retire)
    );

    assign rf_rdata = regs[rf_addr];
    always @(posedge clk) if (rf_we) regs[rf_addr] <= rf_wdata;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%08h exp=%08h", req, act, exp);
        end
    endtask

    function automatic bit ref_legal(input logic [31:0] w);
        logic [6:0] f7 = w[31:25];
        logic [2:0] f3 = w[14:12];
        if (w[6:0] == 7'h33)
            return (f7 == 7'h00) || (f7 == 7'h20 && (f3 == 3'd0 || f3 == 3'd5));
        if (w[6:0] == 7'h13) begin
            if (f3 == 3'd1) return f7 == 7'h00;
            if (f3 == 3'd5) return (f7 == 7'h00) || (f7 == 7'h20);
            return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic logic [31:0] ref_alu(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
        logic [2:0] f3 = w[14:12];
        logic [4:0] sh = b[4:0];
        bit alt = w[30] && (w[6:0] == 7'h33 || f3 == 3'd5);
        case (f3)
            3'd0: return alt ? a - b : a + b;
            3'd1: return a << sh;
            3'd2: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            3'd3: return (a < b) ? 32'd1 : 32'd0;
            3'd4: return a ^ b;
            3'd5: return alt ? $unsigned($signed(a) >>> sh) : a >> sh;
            3'd6: return a | b;
            default: return a & b;
        endcase
    endfunction

    function automatic logic [31:0] mk_r(input logic [6:0] f7, input logic [4:0] s2, input logic [4:0] s1,
                                         input logic [2:0] f3, input logic [4:0] d);
        return {f7, s2, s1, f3, d, 7'h33};
    endfunction

    function automatic logic [31:0] mk_i(input logic [11:0] im, input logic [4:0] s1,
                                         input logic [2:0] f3, input logic [4:0] d);
        return {im, s1, f3, d, 7'h13};
    endfunction

    task automatic run_instr(input logic [31:0] w);
        logic [4:0]  s1 = w[19:15];
        logic [4:0]  s2 = w[24:20];
        logic [4:0]  d  = w[11:7];
        bit          lg = ref_legal(w);
        bit          im = (w[6:0] == 7'h13);
        logic [31:0] a, b, e;
        string       tag;
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = w;
        a = (s1 == 0) ? 32'd0 : regs[s1];
        #1;
        chk(instr_take === 1'b1, "R1 take", {31'd0, instr_take}, 32'd1);
        if (chained) chk(cyc - last_take == 4, "R1 spacing", cyc - last_take, 32'd4);
        last_take = cyc;
        chained   = 1;
        chk(rf_re === 1'b1 && rf_addr == s1, "R2 src1 read", {26'd0, rf_re, rf_addr}, {27'd1, s1});
        @(negedge clk);
        instr_valid = 1'b0;
        instr_word  = $urandom;
        #1;
        b = im ? {{20{w[31]}}, w[31:20]} : ((s2 == 0) ? 32'd0 : regs[s2]);
        if (lg) begin
            if (im) chk(rf_re === 1'b0, "R4 no src2 read", {31'd0, rf_re}, 32'd0);
            else    chk(rf_re === 1'b1 && rf_addr == s2, "R2 src2 read", {26'd0, rf_re, rf_addr}, {27'd1, s2});
        end
        @(negedge clk);
        #1;
        chk(rf_re === 1'b0 && rf_we === 1'b0, "R2 R3 exec idle port", {30'd0, rf_re, rf_we}, 32'd0);
        @(negedge clk);
        #1;
        if (!lg) begin
            chk(trap === 1'b1 && trap_word == w, "R9 trap word", trap_word, w);
            chk(rf_we === 1'b0 && retire === 1'b0, "R9 no write", {30'd0, rf_we, retire}, 32'd0);
        end else begin
            e = ref_alu(w, a, b);
            chk(retire === 1'b1 && trap === 1'b0, "R11 retire", {30'd0, retire, trap}, 32'd2);
            if (d == 0) begin
                chk(rf_we === 1'b0, "R6 x0 write", {31'd0, rf_we}, 32'd0);
            end else begin
                tag = (s1 == 0 || (!im && s2 == 0)) ? "R5 zero operand" : (im ? "R4 R7 imm result" : "R7 result");
                chk(rf_we === 1'b1 && rf_addr == d && rf_re === 1'b0, "R2 R3 write port", {26'd0, rf_we, rf_addr}, {27'd1, d});
                chk(rf_wdata == e, tag, rf_wdata, e);
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            instr_valid = 1'b0;
            instr_word  = $urandom;
            #1;
            chk(instr_take === 1'b0 && rf_re === 1'b0 && rf_we === 1'b0, "R10 idle hold",
                {29'd0, instr_take, rf_re, rf_we}, 32'd0);
        end
        chained = 0;
    endtask

    function automatic logic [31:0] rand_word();
        int sel = $urandom % 8;
        logic [2:0] f3 = $urandom;
        logic [6:0] f7;
        int p = $urandom % 4;
        f7 = (p < 2) ? 7'h00 : (p == 2 ? 7'h20 : 7'($urandom));
        case (sel)
            0, 1, 2: return mk_r(f7, 5'($urandom), 5'($urandom), f3, 5'($urandom));
            3, 4, 5: return (f3 == 3'd1 || f3 == 3'd5)
                        ? mk_i({f7, 5'($urandom)}, 5'($urandom), f3, 5'($urandom))
                        : mk_i(12'($urandom), 5'($urandom), f3, 5'($urandom));
            6: return $urandom;
            default: return {25'($urandom), 7'h13 ^ (7'd1 << ($urandom % 7))};
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) regs[i] = $urandom;
        regs[0] = 32'hDEAD_BEEF;
        regs[1] = 32'h8000_0000;
        regs[2] = 32'hFFFF_FFFF;
        regs[3] = 32'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(trap === 1'b0 && retire === 1'b0 && instr_take === 1'b0, "R10 reset state",
            {29'd0, trap, retire, instr_take}, 32'd0);
        idle(4);
        // directed corners
        run_instr(mk_r(7'h00, 5'd2, 5'd3, 3'd0, 5'd0));  // R6 write to x0
        run_instr(mk_r(7'h00, 5'd0, 5'd0, 3'd6, 5'd10)); // R5 both x0
        run_instr(mk_r(7'h20, 5'd3, 5'd1, 3'd0, 5'd11)); // R7 sub wrap
        run_instr(mk_r(7'h20, 5'd3, 5'd1, 3'd5, 5'd12)); // R7 sra negative
        run_instr(mk_r(7'h00, 5'd3, 5'd1, 3'd2, 5'd13)); // R7 slt signed
        run_instr(mk_r(7'h00, 5'd3, 5'd1, 3'd3, 5'd14)); // R7 sltu
        run_instr(mk_i(12'h800, 5'd3, 3'd0, 5'd15));     // R4 negative imm
        run_instr(mk_i(12'h41F, 5'd1, 3'd5, 5'd16));     // R7 srai 31
        run_instr(mk_r(7'h20, 5'd3, 5'd1, 3'd4, 5'd17)); // R8 alt xor illegal
        run_instr(mk_i(12'h020, 5'd1, 3'd1, 5'd18));     // R8 slli bit25 illegal
        run_instr(32'h0000_0000);                        // R8 all zero
        run_instr(32'hFFFF_FFFF);                        // R8 all ones
        run_instr(mk_i(12'h7FF, 5'd0, 3'd0, 5'd19));     // R9 continues after trap
        idle(3);
        for (int i = 0; i < 400; i++) begin
            run_instr(rand_word());
            if (i % 97 == 0) idle(2);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule